// File: doc/BRIEF.md
# Indirect SDRAM controller register file

This block holds the control and status registers of a memory controller. A register bus sees only two registers: an index register, which selects one internal register, and a window register. Reads and writes of the window register reach whichever internal register the index points at. Each internal register applies its own write mask or forced bits.

Two bus error status registers collect error flags from the controller datapath and are cleared by writing ones. A configuration register carries the global controller enable, exported as `ctl_enable` so a bank decoder can gate all of its mappings. Edges of two configuration bits are mirrored into a read-only status register. An ECC error status register drives a level interrupt while it holds a non-zero value. Four bank configuration words are stored for the bank decoder; their number is a parameter.

Top module: `sdram_csr_indirect`

## Requirements
- R1: After reset the index register reads 0, the error, error address, ECC config, ECC error and status registers read 0, config reads 0x00800000, refresh timer 0x05F00000 and power timer 0x07C00000. `ecc_irq` and `ctl_enable` are low.
- R2: `bus_sel`=0 selects the index register and `bus_sel`=1 the window. The index register reads back exactly what was written. Window accesses are routed by index: 0x00/0x08 error status 0/1, 0x10 error address, 0x20 config, 0x24 status, 0x30 refresh timer, 0x34 power timer, 0x80 timing, 0x94 ECC config, 0x98 ECC error. Bank config i sits at 0x40+4*i and stores the written word unchanged.
- R3: A window read at an index that selects no register returns 0xFFFFFFFF. With `TIMING_READBACK`=0, a read of the timing register also returns 0xFFFFFFFF.
- R4: A window write to an error status register clears exactly the bits written as one. Bits flagged on `err_flags0`/`err_flags1` in the same cycle stay set. The error address register stores the written word unchanged.
- R5: A config write keeps bits 31:21 and zeroes the rest. `ctl_enable` equals config bit 31, one cycle after the write.
- R6: When config bit 31 goes 0 to 1, status bit 31 clears. When it goes 1 to 0, status bit 31 sets. A write that leaves the bit unchanged leaves status bit 31 unchanged.
- R7: When config bit 30 goes 0 to 1, status bit 30 sets, and when it goes 1 to 0, status bit 30 clears. Writes to the status register have no effect.
- R8: The refresh timer stores the written value AND 0x3FF80000, and ECC config stores it AND 0x00F00000. Timing stores it AND 0x018FC01F, readable only when `TIMING_READBACK`=1. The power timer stores (value AND 0xF8000000) OR 0x07C00000.
- R9: ECC error writes store the value AND 0xFFF0F000. `ecc_irq` is high from the cycle after a write that leaves the register non-zero, and low from the cycle after a write that leaves it zero.
- R10: A bank index at or beyond `NUM_BANKS` is an unlisted index and reads 0xFFFFFFFF.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| bus_wr | input | 1 | Single-cycle write strobe |
| bus_rd | input | 1 | Single-cycle read strobe |
| bus_sel | input | 1 | 0 = index register, 1 = window register |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data, valid in the read strobe cycle, 0 otherwise |
| err_flags0 | input | 32 | Error flags ORed into error status 0 each cycle |
| err_flags1 | input | 32 | Error flags ORed into error status 1 each cycle |
| ctl_enable | output | 1 | Global controller enable (config bit 31) |
| ecc_irq | output | 1 | Level interrupt, high while ECC error status is non-zero |

## Verification
The bench drives two instances from the same stimulus. The first uses the default build: four banks and timing reads returning all ones. The second has `NUM_BANKS`=2 and `TIMING_READBACK`=1. The second build makes the timing write mask observable at the port. It also turns the third and fourth bank indices into unlisted indices, so the read-all-ones path is exercised there as well.

// File: rtl/sdcsr_pkg.sv
package sdcsr_pkg;
  localparam int CSR_W = 32;
  typedef logic [CSR_W-1:0] word_t;

  // internal register indices (the bank decoder depends on the bank spacing)
  localparam word_t IX_ESR0  = 32'h00;
  localparam word_t IX_ESR1  = 32'h08;
  localparam word_t IX_EADDR = 32'h10;
  localparam word_t IX_CFG   = 32'h20;
  localparam word_t IX_STAT  = 32'h24;
  localparam word_t IX_RFSH  = 32'h30;
  localparam word_t IX_PWR   = 32'h34;
  localparam word_t IX_BANK0 = 32'h40;
  localparam int    BANK_STRIDE = 4;
  localparam word_t IX_TIM   = 32'h80;
  localparam word_t IX_ECFG  = 32'h94;
  localparam word_t IX_EERR  = 32'h98;

  localparam word_t MSK_CFG  = 32'hFFE0_0000;
  localparam word_t MSK_RFSH = 32'h3FF8_0000;
  localparam word_t MSK_TIM  = 32'h018F_C01F;
  localparam word_t MSK_ECFG = 32'h00F0_0000;
  localparam word_t MSK_EERR = 32'hFFF0_F000;
  localparam word_t PWR_KEEP = 32'hF800_0000;
  localparam word_t PWR_SET  = 32'h07C0_0000;

  localparam word_t RST_CFG  = 32'h0080_0000;
  localparam word_t RST_RFSH = 32'h05F0_0000;
  localparam word_t RST_PWR  = 32'h07C0_0000;
  localparam word_t RST_TIM  = 32'h0085_4009;

  localparam int BIT_EN = 31;
  localparam int BIT_LP = 30;

  typedef struct packed {
    logic esr0;
    logic esr1;
    logic eaddr;
    logic cfg;
    logic stat;
    logic rfsh;
    logic pwr;
    logic tim;
    logic ecfg;
    logic eerr;
  } sel_t;

  function automatic word_t keep_bits(word_t v, word_t m);
    return v & m;
  endfunction

  function automatic word_t pwr_value(word_t v);
    return (v & PWR_KEEP) | PWR_SET;
  endfunction

  function automatic word_t w1c_next(word_t cur, word_t clr, word_t set);
    return (cur & ~clr) | set;
  endfunction
endpackage

// File: rtl/sdcsr_decode.sv
module sdcsr_decode
  import sdcsr_pkg::*;
#(
  parameter int NUM_BANKS = 4
) (
  input  word_t                idx,
  output sel_t                 sel,
  output logic [NUM_BANKS-1:0] bank_hit,
  output logic                 known
);
  always_comb begin
    sel.esr0  = (idx == IX_ESR0);
    sel.esr1  = (idx == IX_ESR1);
    sel.eaddr = (idx == IX_EADDR);
    sel.cfg   = (idx == IX_CFG);
    sel.stat  = (idx == IX_STAT);
    sel.rfsh  = (idx == IX_RFSH);
    sel.pwr   = (idx == IX_PWR);
    sel.tim   = (idx == IX_TIM);
    sel.ecfg  = (idx == IX_ECFG);
    sel.eerr  = (idx == IX_EERR);
  end

  for (genvar i = 0; i < NUM_BANKS; i++) begin : g_bank
    assign bank_hit[i] = (idx == IX_BANK0 + word_t'(i * BANK_STRIDE));
  end

  assign known = (|sel) | (|bank_hit);
endmodule

// File: rtl/sdcsr_err_regs.sv
module sdcsr_err_regs
  import sdcsr_pkg::*;
(
  input  logic  clk,
  input  logic  rst_n,
  input  logic  wr_esr0,
  input  logic  wr_esr1,
  input  logic  wr_eaddr,
  input  word_t wdata,
  input  word_t flags0,
  input  word_t flags1,
  output word_t esr0_q,
  output word_t esr1_q,
  output word_t eaddr_q
);
  word_t clr0, clr1;
  assign clr0 = wr_esr0 ? wdata : '0;
  assign clr1 = wr_esr1 ? wdata : '0;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      esr0_q  <= '0;
      esr1_q  <= '0;
      eaddr_q <= '0;
    end else begin
      esr0_q <= w1c_next(esr0_q, clr0, flags0);
      esr1_q <= w1c_next(esr1_q, clr1, flags1);
      if (wr_eaddr) eaddr_q <= wdata;
    end
  end

  AST_W1C_CLEARS0: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_esr0 && flags0 == '0) |=> ((esr0_q & $past(wdata)) == '0)); // R4
  AST_FLAG_WINS1: assert property (@(posedge clk) disable iff (!rst_n)
    (flags1 != '0) |=> ((esr1_q & $past(flags1)) == $past(flags1))); // R4
endmodule

// File: rtl/sdcsr_ctrl.sv
module sdcsr_ctrl
  import sdcsr_pkg::*;
(
  input  logic  clk,
  input  logic  rst_n,
  input  logic  wr_cfg,
  input  word_t wdata,
  output word_t cfg_q,
  output word_t stat_q
);
  word_t cfg_nv;
  logic  en_rise, en_fall, lp_rise, lp_fall;

  assign cfg_nv  = keep_bits(wdata, MSK_CFG);
  assign en_rise = wr_cfg & ~cfg_q[BIT_EN] &  cfg_nv[BIT_EN];
  assign en_fall = wr_cfg &  cfg_q[BIT_EN] & ~cfg_nv[BIT_EN];
  assign lp_rise = wr_cfg & ~cfg_q[BIT_LP] &  cfg_nv[BIT_LP];
  assign lp_fall = wr_cfg &  cfg_q[BIT_LP] & ~cfg_nv[BIT_LP];

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      cfg_q  <= RST_CFG;
      stat_q <= '0;
    end else begin
      if (wr_cfg) cfg_q <= cfg_nv;
      if (en_rise) stat_q[BIT_EN] <= 1'b0;
      else if (en_fall) stat_q[BIT_EN] <= 1'b1;
      if (lp_rise) stat_q[BIT_LP] <= 1'b1;
      else if (lp_fall) stat_q[BIT_LP] <= 1'b0;
    end
  end

  AST_EN_RISE_CLEARS: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(cfg_q[BIT_EN]) |-> !stat_q[BIT_EN]); // R6
  AST_EN_FALL_SETS: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(cfg_q[BIT_EN]) |-> stat_q[BIT_EN]); // R6
  AST_LP_MIRROR: assert property (@(posedge clk) disable iff (!rst_n)
    ($rose(cfg_q[BIT_LP]) || $fell(cfg_q[BIT_LP])) |-> (stat_q[BIT_LP] == cfg_q[BIT_LP])); // R7
  AST_STAT_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    !wr_cfg |=> $stable(stat_q)); // R7
  AST_CFG_LOW_CLEAR: assert property (@(posedge clk) disable iff (!rst_n)
    wr_cfg |=> (cfg_q[20:0] == '0)); // R5
endmodule

// File: rtl/sdcsr_ecc.sv
module sdcsr_ecc
  import sdcsr_pkg::*;
(
  input  logic  clk,
  input  logic  rst_n,
  input  logic  wr_ecfg,
  input  logic  wr_eerr,
  input  word_t wdata,
  output word_t ecfg_q,
  output word_t eerr_q,
  output logic  irq_q
);
  word_t eerr_nv;
  logic  err_nz;

  assign eerr_nv = keep_bits(wdata, MSK_EERR);
  assign err_nz  = (eerr_nv != '0);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      ecfg_q <= '0;
      eerr_q <= '0;
      irq_q  <= 1'b0;
    end else begin
      if (wr_ecfg) ecfg_q <= keep_bits(wdata, MSK_ECFG);
      if (wr_eerr) begin
        eerr_q <= eerr_nv;
        irq_q  <= err_nz;
      end
    end
  end

  AST_IRQ_LEVEL: assert property (@(posedge clk) disable iff (!rst_n)
    irq_q == (eerr_q != '0)); // R9
  AST_IRQ_RAISE: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_eerr && (wdata & MSK_EERR) != '0) |=> irq_q); // R9
  AST_IRQ_DROP: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_eerr && (wdata & MSK_EERR) == '0) |=> !irq_q); // R9
endmodule

// File: rtl/sdram_csr_indirect.sv
module sdram_csr_indirect
  import sdcsr_pkg::*;
#(
  parameter int NUM_BANKS       = 4,
  parameter bit TIMING_READBACK = 1'b0
) (
  input  logic        clk,
  input  logic        rst_n,
  input  logic        bus_wr,
  input  logic        bus_rd,
  input  logic        bus_sel,
  input  logic [31:0] bus_wdata,
  output logic [31:0] bus_rdata,
  input  logic [31:0] err_flags0,
  input  logic [31:0] err_flags1,
  output logic        ctl_enable,
  output logic        ecc_irq
);
  word_t idx_q;
  word_t rfsh_q, pwr_q, tim_q;
  word_t bank_q [NUM_BANKS];
  word_t esr0_q, esr1_q, eaddr_q, cfg_q, stat_q, ecfg_q, eerr_q;
  word_t win_rd;
  sel_t  sel;
  logic [NUM_BANKS-1:0] bank_hit;
  logic  known;
  logic  wr_idx, wr_win, irq_q;

  assign wr_idx = bus_wr & ~bus_sel;
  assign wr_win = bus_wr &  bus_sel;

  sdcsr_decode #(.NUM_BANKS(NUM_BANKS)) u_dec (
    .idx(idx_q), .sel(sel), .bank_hit(bank_hit), .known(known)
  );

  sdcsr_err_regs u_err (
    .clk(clk), .rst_n(rst_n),
    .wr_esr0(wr_win & sel.esr0), .wr_esr1(wr_win & sel.esr1),
    .wr_eaddr(wr_win & sel.eaddr), .wdata(bus_wdata),
    .flags0(err_flags0), .flags1(err_flags1),
    .esr0_q(esr0_q), .esr1_q(esr1_q), .eaddr_q(eaddr_q)
  );

  sdcsr_ctrl u_ctl (
    .clk(clk), .rst_n(rst_n), .wr_cfg(wr_win & sel.cfg), .wdata(bus_wdata),
    .cfg_q(cfg_q), .stat_q(stat_q)
  );

  sdcsr_ecc u_ecc (
    .clk(clk), .rst_n(rst_n),
    .wr_ecfg(wr_win & sel.ecfg), .wr_eerr(wr_win & sel.eerr), .wdata(bus_wdata),
    .ecfg_q(ecfg_q), .eerr_q(eerr_q), .irq_q(irq_q)
  );

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      idx_q  <= '0;
      rfsh_q <= RST_RFSH;
      pwr_q  <= RST_PWR;
      tim_q  <= RST_TIM;
      for (int i = 0; i < NUM_BANKS; i++) bank_q[i] <= '0;
    end else begin
      if (wr_idx) idx_q <= bus_wdata;
      if (wr_win && sel.rfsh) rfsh_q <= keep_bits(bus_wdata, MSK_RFSH);
      if (wr_win && sel.pwr)  pwr_q  <= pwr_value(bus_wdata);
      if (wr_win && sel.tim)  tim_q  <= keep_bits(bus_wdata, MSK_TIM);
      for (int i = 0; i < NUM_BANKS; i++)
        if (wr_win && bank_hit[i]) bank_q[i] <= bus_wdata;
    end
  end

  always_comb begin
    win_rd = '1;
    if (sel.esr0)  win_rd = esr0_q;
    if (sel.esr1)  win_rd = esr1_q;
    if (sel.eaddr) win_rd = eaddr_q;
    if (sel.cfg)   win_rd = cfg_q;
    if (sel.stat)  win_rd = stat_q;
    if (sel.rfsh)  win_rd = rfsh_q;
    if (sel.pwr)   win_rd = pwr_q;
    if (sel.tim)   win_rd = TIMING_READBACK ? tim_q : '1;
    if (sel.ecfg)  win_rd = ecfg_q;
    if (sel.eerr)  win_rd = eerr_q;
    for (int i = 0; i < NUM_BANKS; i++)
      if (bank_hit[i]) win_rd = bank_q[i];
  end

  assign bus_rdata  = !bus_rd ? '0 : (bus_sel ? win_rd : idx_q);
  assign ctl_enable = cfg_q[BIT_EN];
  assign ecc_irq    = irq_q;

  AST_UNLISTED_ONES: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_rd && bus_sel && !known) |-> (bus_rdata == '1)); // R3
  AST_IDX_READBACK: assert property (@(posedge clk) disable iff (!rst_n)
    wr_idx |=> (idx_q == $past(bus_wdata))); // R2
  AST_ENABLE_TRACK: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_win && sel.cfg) |=> (ctl_enable == $past(bus_wdata[BIT_EN]))); // R5
endmodule

// File: tb/tb_sdram_csr_indirect.sv
`timescale 1ns/1ps
module tb_sdram_csr_indirect;
  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic bus_wr = 1'b0, bus_rd = 1'b0, bus_sel = 1'b0;
  logic [31:0] bus_wdata = '0, flags0 = '0, flags1 = '0;
  logic [31:0] rdata, rdata_alt;
  logic en, en_alt, irq, irq_alt;
  int checks = 0, fails = 0;

  always #2 clk = ~clk;

  sdram_csr_indirect dut (
    .clk(clk), .rst_n(rst_n), .bus_wr(bus_wr), .bus_rd(bus_rd), .bus_sel(bus_sel),
    .bus_wdata(bus_wdata), .bus_rdata(rdata), .err_flags0(flags0), .err_flags1(flags1),
    .ctl_enable(en), .ecc_irq(irq)
  );

  sdram_csr_indirect #(.NUM_BANKS(2), .TIMING_READBACK(1'b1)) dut_alt (
    .clk(clk), .rst_n(rst_n), .bus_wr(bus_wr), .bus_rd(bus_rd), .bus_sel(bus_sel),
    .bus_wdata(bus_wdata), .bus_rdata(rdata_alt), .err_flags0(flags0), .err_flags1(flags1),
    .ctl_enable(en_alt), .ecc_irq(irq_alt)
  );

  task automatic check(string tag, logic [31:0] got, logic [31:0] exp);
    checks++;
    if (got !== exp) begin
      fails++;
      $display("FAIL %s got=%h exp=%h", tag, got, exp);
    end
  endtask

  task automatic bus_write(logic sel, logic [31:0] d);
    @(negedge clk);
    bus_wr = 1'b1; bus_sel = sel; bus_wdata = d;
    @(negedge clk);
    bus_wr = 1'b0; bus_wdata = '0;
  endtask

  task automatic wr_reg(logic [31:0] ix, logic [31:0] d);
    bus_write(1'b0, ix);
    bus_write(1'b1, d);
  endtask

  task automatic rd_reg(logic [31:0] ix, output logic [31:0] v, output logic [31:0] va);
    bus_write(1'b0, ix);
    @(negedge clk);
    bus_rd = 1'b1; bus_sel = 1'b1;
    #1;
    v = rdata; va = rdata_alt;
    @(negedge clk);
    bus_rd = 1'b0;
  endtask

  task automatic expect_reg(string tag, logic [31:0] ix, logic [31:0] exp);
    logic [31:0] v, va;
    rd_reg(ix, v, va);
    check(tag, v, exp);
  endtask

  task automatic t_reset();
    logic [31:0] v, va;
    @(negedge clk);
    bus_rd = 1'b1; bus_sel = 1'b0;
    #1;
    check("R1 index", rdata, 32'h0);
    @(negedge clk);
    bus_rd = 1'b0;
    check("R1 enable", {31'b0, en}, 32'h0);
    check("R1 irq", {31'b0, irq}, 32'h0);
    expect_reg("R1 cfg", 32'h20, 32'h0080_0000);
    expect_reg("R1 status", 32'h24, 32'h0);
    expect_reg("R1 refresh", 32'h30, 32'h05F0_0000);
    expect_reg("R1 power", 32'h34, 32'h07C0_0000);
    expect_reg("R1 esr0", 32'h00, 32'h0);
    expect_reg("R1 eaddr", 32'h10, 32'h0);
    expect_reg("R1 eccerr", 32'h98, 32'h0);
    rd_reg(32'h80, v, va);
    check("R1 timing alt", va, 32'h0085_4009);
  endtask

  task automatic t_index_and_banks();
    logic [31:0] v, va;
    bus_write(1'b0, 32'hDEAD_BEEF);
    @(negedge clk);
    bus_rd = 1'b1; bus_sel = 1'b0;
    #1;
    check("R2 index readback", rdata, 32'hDEAD_BEEF);
    @(negedge clk);
    bus_rd = 1'b0;
    for (int i = 0; i < 4; i++) wr_reg(32'h40 + 4 * i, 32'hA5A5_0000 + i);
    for (int i = 0; i < 4; i++) begin
      rd_reg(32'h40 + 4 * i, v, va);
      check("R2 bank", v, 32'hA5A5_0000 + i);
      if (i < 2) check("R2 bank alt", va, 32'hA5A5_0000 + i);
      else       check("R10 bank beyond count", va, 32'hFFFF_FFFF);
    end
  endtask

  task automatic t_unlisted_and_masks();
    logic [31:0] v, va;
    rd_reg(32'h04, v, va);
    check("R3 unlisted", v, 32'hFFFF_FFFF);
    rd_reg(32'h99, v, va);
    check("R3 unlisted odd", v, 32'hFFFF_FFFF);
    wr_reg(32'h80, 32'hFFFF_FFFF);
    rd_reg(32'h80, v, va);
    check("R3 timing ones", v, 32'hFFFF_FFFF);
    check("R8 timing mask", va, 32'h018F_C01F);
    wr_reg(32'h30, 32'hFFFF_FFFF);
    expect_reg("R8 refresh mask", 32'h30, 32'h3FF8_0000);
    wr_reg(32'h34, 32'h0);
    expect_reg("R8 power forced", 32'h34, 32'h07C0_0000);
    wr_reg(32'h34, 32'hFFFF_FFFF);
    expect_reg("R8 power all", 32'h34, 32'hFFC0_0000);
    wr_reg(32'h94, 32'hFFFF_FFFF);
    expect_reg("R8 ecc cfg mask", 32'h94, 32'h00F0_0000);
  endtask

  task automatic t_errors();
    @(negedge clk);
    flags0 = 32'h0000_00F0; flags1 = 32'h0000_0003;
    @(negedge clk);
    flags0 = '0; flags1 = '0;
    expect_reg("R4 flag set", 32'h00, 32'h0000_00F0);
    wr_reg(32'h00, 32'h0000_0030);
    expect_reg("R4 w1c esr0", 32'h00, 32'h0000_00C0);
    wr_reg(32'h08, 32'h0000_0001);
    expect_reg("R4 w1c esr1", 32'h08, 32'h0000_0002);
    bus_write(1'b0, 32'h08);
    @(negedge clk);
    bus_wr = 1'b1; bus_sel = 1'b1; bus_wdata = 32'h0000_0001; flags1 = 32'h0000_0001;
    @(negedge clk);
    bus_wr = 1'b0; bus_wdata = '0; flags1 = '0;
    expect_reg("R4 flag beats clear", 32'h08, 32'h0000_0003);
    wr_reg(32'h10, 32'h1234_5678);
    expect_reg("R4 eaddr", 32'h10, 32'h1234_5678);
  endtask

  task automatic t_config();
    wr_reg(32'h20, 32'hFFFF_FFFF);
    check("R5 enable high", {31'b0, en}, 32'h1);
    expect_reg("R5 cfg mask", 32'h20, 32'hFFE0_0000);
    expect_reg("R6 R7 status after rise", 32'h24, 32'h4000_0000);
    wr_reg(32'h24, 32'hFFFF_FFFF);
    expect_reg("R7 status ignores write", 32'h24, 32'h4000_0000);
    wr_reg(32'h20, 32'h0);
    check("R5 enable low", {31'b0, en}, 32'h0);
    expect_reg("R6 status after fall", 32'h24, 32'h8000_0000);
    wr_reg(32'h20, 32'h0);
    expect_reg("R6 no edge no change", 32'h24, 32'h8000_0000);
    wr_reg(32'h20, 32'h8000_0000);
    expect_reg("R6 second rise", 32'h24, 32'h0);
  endtask

  task automatic t_ecc();
    wr_reg(32'h98, 32'h000F_0FFF);
    check("R9 masked zero irq", {31'b0, irq}, 32'h0);
    expect_reg("R9 masked zero", 32'h98, 32'h0);
    wr_reg(32'h98, 32'hFFFF_FFFF);
    check("R9 irq raise", {31'b0, irq}, 32'h1);
    expect_reg("R9 eccerr mask", 32'h98, 32'hFFF0_F000);
    wr_reg(32'h98, 32'h0000_1000);
    check("R9 irq stays", {31'b0, irq}, 32'h1);
    wr_reg(32'h98, 32'h0);
    check("R9 irq drop", {31'b0, irq}, 32'h0);
  endtask

  initial begin
    repeat (20000) @(posedge clk);
    fails++;
    $display("FAIL watchdog expired");
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    t_reset();
    t_index_and_banks();
    t_unlisted_and_masks();
    t_errors();
    t_config();
    t_ecc();
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end
endmodule